// File: doc/BRIEF.md
# Serial Receiver Mute and Wakeup Controller

This block sits beside an asynchronous serial receiver on a multi-drop link. It lets a node that is not being addressed stop reporting traffic. While the node is muted, incoming frames and idle events raise no receive flag and no receive interrupt. The receiver core supplies a strobe for each completed frame, with the received byte, and a strobe for each detected idle frame. The controller decides whether each event reaches the status flags and whether it moves the mute state.

Two wake methods are offered.

- **Idle-line wake:** software pulses a mute request, and the node stays silent until the line goes idle.
- **Address wake:** a received byte with its top bit set is an address. The node wakes when the low 4 or 7 bits of that byte equal its programmed node address. It silences itself when an address names another node.

Outside mute, the block holds a receive-not-empty flag with the byte, an idle flag, and a combined interrupt.

Top module: `uart_mute_wake`

## Requirements
- R1: With `mute_en` low, `mute_o` stays 0, `mute_req` has no effect, and each accepted frame sets `rxne_o` and loads `rx_data_o` one clock after its strobe.
- R2: While `mute_o` is 1, no frame or idle strobe sets `rxne_o` or `idle_o`, and `rx_irq_o` is 0.
- R3: With `wake_sel`=0, a `mute_req` pulse on a line that is not idle sets `mute_o` one clock later.
- R4: With `wake_sel`=0 and the block muted, an idle strobe clears `mute_o` one clock later and leaves `idle_o` at 0.
- R5: With `wake_sel`=0, a `mute_req` pulse is ignored when the most recent receive event was an idle strobe.
- R6: After `rx_enable` has been low, the line counts as busy until the next idle strobe, so a mute request made then is accepted.
- R7: With `wake_sel`=1, a byte with bit 7 = 0 is data. It never changes `mute_o`, and it is reported only when the block is not muted.
- R8: With `wake_sel`=1 and `addr7_sel`=0, an address byte matches when bits 3:0 equal `node_addr[3:0]`. Bits 6:4 are ignored.
- R9: With `wake_sel`=1 and `addr7_sel`=1, an address byte matches when bits 6:0 equal `node_addr`.
- R10: With `wake_sel`=1, a matching address byte clears `mute_o` and is not reported if the block was muted. A non-matching address byte sets `mute_o` and is not reported.
- R11: The first frame after a wakeup is reported normally: `rxne_o` rises, and `rx_irq_o` rises in the same cycle if `rxne_ie` is 1.
- R12: Reset clears every output. Clearing `mute_en` forces `mute_o` to 0 on the next clock.
- R13: `rxne_clr` and `idle_clr` clear their flags one clock later. `rx_irq_o` equals (`rxne_o` & `rxne_ie`) | (`idle_o` & `idle_ie`) on every cycle that is not muted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_en | input | 1 | Enables mute behaviour |
| wake_sel | input | 1 | 0 selects idle-line wake, 1 selects address wake |
| addr7_sel | input | 1 | 1 compares 7 address bits, 0 compares 4 |
| node_addr | input | 7 | Programmed address of this node |
| rx_enable | input | 1 | Receiver enabled; strobes are ignored when low |
| mute_req | input | 1 | Software mute request pulse |
| frame_stb | input | 1 | Frame-complete strobe from the receiver core |
| frame_byte | input | 8 | Received byte, valid with `frame_stb` |
| idle_stb | input | 1 | Idle-frame-detected strobe |
| rxne_clr | input | 1 | Clears the receive-not-empty flag |
| idle_clr | input | 1 | Clears the idle flag |
| rxne_ie | input | 1 | Receive-not-empty interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| mute_o | output | 1 | Mute status |
| rxne_o | output | 1 | Receive-not-empty flag |
| idle_o | output | 1 | Idle flag |
| rx_data_o | output | 8 | Last reported byte |
| rx_irq_o | output | 1 | Combined receive interrupt |

## Verification
A wrong mute state is visible on `mute_o` one clock after the strobe or request that caused it. A few frames later it also shows as a missing or extra `rxne_o` rise, because the next frame is reported or silenced against that state.

A wrong line-idle record cannot be seen directly. It appears only when the next idle-mode mute request is wrongly accepted or wrongly refused.

A faulty address mask shows as a wake or re-mute on the wrong byte. That byte then leaks into `rx_data_o`, or the following data byte is lost. Every output is therefore compared each clock against a model, and directed cases place requests and strobes on both sides of these conditions.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_e;

  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned WIDE_W_DEF   = 7;
  localparam int unsigned NARROW_W_DEF = 4;
endpackage

// File: rtl/mute_addr_match.sv
module mute_addr_match #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIDE_W   = 7,
  parameter int unsigned NARROW_W = 4
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [WIDE_W-1:0] node_addr,
  input  logic              wide_sel,
  output logic              is_addr,
  output logic              hit
);
  localparam int unsigned MARK_BIT = DATA_W - 1;

  logic [WIDE_W-1:0] cmp_mask;
  logic [WIDE_W-1:0] bit_eq;

  genvar gi;
  generate
    for (gi = 0; gi < WIDE_W; gi++) begin : g_mask
      if (gi < NARROW_W) begin : g_low
        assign cmp_mask[gi] = 1'b1;
      end else begin : g_high
        assign cmp_mask[gi] = wide_sel;
      end
      assign bit_eq[gi] = (rx_byte[gi] == node_addr[gi]) | ~cmp_mask[gi];
    end
  endgenerate

  assign is_addr = rx_byte[MARK_BIT];
  assign hit     = &bit_eq;
endmodule

// File: rtl/mute_ctrl.sv
module mute_ctrl
  import uart_mute_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mute_en,
  input  wake_e wake_sel,
  input  logic  rx_enable,
  input  logic  mute_req,
  input  logic  frame_stb,
  input  logic  idle_stb,
  input  logic  is_addr,
  input  logic  hit,
  output logic  mute_q,
  output logic  mute_nx,
  output logic  accept_frame,
  output logic  accept_idle
);
  logic line_idle_q, line_idle_d;
  logic frame_ev, idle_ev, addr_ev;

  assign frame_ev = rx_enable & frame_stb;
  assign idle_ev  = rx_enable & idle_stb & ~frame_stb;
  assign addr_ev  = frame_ev & mute_en & (wake_sel == WAKE_ADDR) & is_addr;

  always_comb begin
    mute_nx      = mute_q;
    line_idle_d  = line_idle_q;
    accept_frame = 1'b0;
    accept_idle  = 1'b0;
    if (!rx_enable) begin
      line_idle_d = 1'b0;
    end
    if (frame_ev) begin
      line_idle_d = 1'b0;
      if (addr_ev) begin
        mute_nx      = ~hit;
        accept_frame = ~mute_q & hit;
      end else begin
        accept_frame = ~mute_q;
      end
    end else if (idle_ev) begin
      line_idle_d = 1'b1;
      if (mute_q) begin
        if (wake_sel == WAKE_IDLE) mute_nx = 1'b0;
      end else begin
        accept_idle = 1'b1;
      end
    end else if (mute_req && mute_en) begin
      if (wake_sel == WAKE_ADDR || !line_idle_q) mute_nx = 1'b1;
    end
    if (!mute_en) mute_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_q      <= 1'b0;
      line_idle_q <= 1'b0;
    end else begin
      mute_q      <= mute_nx;
      line_idle_q <= line_idle_d;
    end
  end

  // R12
  mute_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !mute_en |=> !mute_q);

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_en && mute_q && wake_sel == WAKE_IDLE && rx_enable && idle_stb && !frame_stb)
    |=> !mute_q);

  // R5
  idle_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!mute_q && line_idle_q && wake_sel == WAKE_IDLE && mute_req && !frame_stb && !idle_stb)
    |=> !mute_q);

  // R10
  addr_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_en && wake_sel == WAKE_ADDR && rx_enable && frame_stb && is_addr && hit)
    |=> !mute_q);

  // R10
  addr_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_en && wake_sel == WAKE_ADDR && rx_enable && frame_stb && is_addr && !hit)
    |=> mute_q);

  // R7
  data_keeps_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_en && wake_sel == WAKE_ADDR && rx_enable && frame_stb && !is_addr)
    |=> mute_q == $past(mute_q));
endmodule

// File: rtl/rx_flag_gate.sv
module rx_flag_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mute_q,
  input  logic              mute_nx,
  input  logic              accept_frame,
  input  logic              accept_idle,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rxne_clr,
  input  logic              idle_clr,
  input  logic              rxne_ie,
  input  logic              idle_ie,
  output logic              rxne_q,
  output logic              idle_q,
  output logic [DATA_W-1:0] data_q,
  output logic              irq_q
);
  logic rxne_d, idle_d, irq_d;

  always_comb begin
    rxne_d = rxne_q;
    idle_d = idle_q;
    if (rxne_clr) rxne_d = 1'b0;
    if (idle_clr) idle_d = 1'b0;
    if (accept_frame) rxne_d = 1'b1;
    if (accept_idle) idle_d = 1'b1;
    irq_d = ~mute_nx & ((rxne_d & rxne_ie) | (idle_d & idle_ie));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxne_q <= 1'b0;
      idle_q <= 1'b0;
      irq_q  <= 1'b0;
      data_q <= '0;
    end else begin
      rxne_q <= rxne_d;
      idle_q <= idle_d;
      irq_q  <= irq_d;
      if (accept_frame) data_q <= rx_byte;
    end
  end

  // R2
  quiet_rxne_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_q && !rxne_q) |=> !rxne_q);

  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_q && !idle_q) |=> !idle_q);

  // R13
  rxne_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rxne_clr && !accept_frame) |=> !rxne_q);
endmodule

// File: rtl/uart_mute_wake.sv
module uart_mute_wake
  import uart_mute_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned WIDE_W   = WIDE_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mute_en,
  input  logic              wake_sel,
  input  logic              addr7_sel,
  input  logic [WIDE_W-1:0] node_addr,
  input  logic              rx_enable,
  input  logic              mute_req,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              idle_stb,
  input  logic              rxne_clr,
  input  logic              idle_clr,
  input  logic              rxne_ie,
  input  logic              idle_ie,
  output logic              mute_o,
  output logic              rxne_o,
  output logic              idle_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_irq_o
);
  logic  is_addr, hit;
  logic  mute_q, mute_nx, acc_f, acc_i;
  wake_e wake_m;

  assign wake_m = wake_e'(wake_sel);

  mute_addr_match #(
    .DATA_W  (DATA_W),
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W)
  ) u_match (
    .rx_byte  (frame_byte),
    .node_addr(node_addr),
    .wide_sel (addr7_sel),
    .is_addr  (is_addr),
    .hit      (hit)
  );

  mute_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .mute_en     (mute_en),
    .wake_sel    (wake_m),
    .rx_enable   (rx_enable),
    .mute_req    (mute_req),
    .frame_stb   (frame_stb),
    .idle_stb    (idle_stb),
    .is_addr     (is_addr),
    .hit         (hit),
    .mute_q      (mute_q),
    .mute_nx     (mute_nx),
    .accept_frame(acc_f),
    .accept_idle (acc_i)
  );

  rx_flag_gate #(.DATA_W(DATA_W)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .mute_q      (mute_q),
    .mute_nx     (mute_nx),
    .accept_frame(acc_f),
    .accept_idle (acc_i),
    .rx_byte     (frame_byte),
    .rxne_clr    (rxne_clr),
    .idle_clr    (idle_clr),
    .rxne_ie     (rxne_ie),
    .idle_ie     (idle_ie),
    .rxne_q      (rxne_o),
    .idle_q      (idle_o),
    .data_q      (rx_data_o),
    .irq_q       (rx_irq_o)
  );

  assign mute_o = mute_q;

  // R2
  muted_irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    mute_o |-> !rx_irq_o);

  // R4
  wake_no_idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_o && !idle_o && idle_stb) |=> !idle_o);

  // R1
  disabled_unmuted_chk: assert property (@(posedge clk) disable iff (rst)
    (!mute_en && $past(!mute_en)) |-> !mute_o);
endmodule

// File: tb/tb_uart_mute_wake.sv
module tb_uart_mute_wake;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mute_en = 1'b0, wake_sel = 1'b0, addr7_sel = 1'b1;
  logic [6:0] node_addr = 7'h25;
  logic       rx_enable = 1'b1, mute_req = 1'b0, frame_stb = 1'b0, idle_stb = 1'b0;
  logic [7:0] frame_byte = 8'h00;
  logic       rxne_clr = 1'b0, idle_clr = 1'b0, rxne_ie = 1'b0, idle_ie = 1'b0;
  logic       mute_o, rxne_o, idle_o, rx_irq_o;
  logic [7:0] rx_data_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  logic       m_mute = 0, m_lidle = 0, m_rxne = 0, m_idle = 0, m_irq = 0;
  logic [7:0] m_data = 0;

  uart_mute_wake dut (
    .clk(clk), .rst(rst), .mute_en(mute_en), .wake_sel(wake_sel),
    .addr7_sel(addr7_sel), .node_addr(node_addr), .rx_enable(rx_enable),
    .mute_req(mute_req), .frame_stb(frame_stb), .frame_byte(frame_byte),
    .idle_stb(idle_stb), .rxne_clr(rxne_clr), .idle_clr(idle_clr),
    .rxne_ie(rxne_ie), .idle_ie(idle_ie), .mute_o(mute_o), .rxne_o(rxne_o),
    .idle_o(idle_o), .rx_data_o(rx_data_o), .rx_irq_o(rx_irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic addr_hit(logic [7:0] b, logic [6:0] n, logic wide);
    if (wide) return b[6:0] == n;
    return b[3:0] == n[3:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Expected next state from the requirements, then one clock.
  task automatic tick();
    logic nm, nl, nr, ni, af, ai;
    logic [7:0] nd;
    nm = m_mute; nl = m_lidle; nr = m_rxne; ni = m_idle; nd = m_data;
    af = 0; ai = 0;
    if (!rx_enable) nl = 0;
    if (rx_enable && frame_stb) begin
      nl = 0;
      if (mute_en && wake_sel && frame_byte[7]) begin
        nm = !addr_hit(frame_byte, node_addr, addr7_sel);
        af = !m_mute && !nm;
      end else af = !m_mute;
    end else if (rx_enable && idle_stb) begin
      nl = 1;
      if (m_mute) begin if (!wake_sel) nm = 0; end
      else ai = 1;
    end else if (mute_req && mute_en) begin
      if (wake_sel || !m_lidle) nm = 1;
    end
    if (!mute_en) nm = 0;
    if (rxne_clr) nr = 0;
    if (idle_clr) ni = 0;
    if (af) begin nr = 1; nd = frame_byte; end
    if (ai) ni = 1;
    @(posedge clk);
    #1;
    cycles++;
    if (rst) begin
      m_mute = 0; m_lidle = 0; m_rxne = 0; m_idle = 0; m_data = 0; m_irq = 0;
    end else begin
      m_mute = nm; m_lidle = nl; m_rxne = nr; m_idle = ni; m_data = nd;
      m_irq = !nm && ((nr && rxne_ie) || (ni && idle_ie));
    end
  endtask

  task automatic cmp_model(string tag);
    chk({tag, " mute"}, mute_o, m_mute);
    chk({tag, " rxne"}, rxne_o, m_rxne);
    chk({tag, " idle"}, idle_o, m_idle);
    chk({tag, " irq"},  rx_irq_o, m_irq);
    chk({tag, " data"}, rx_data_o, m_data);
  endtask

  task automatic send(logic [7:0] b);
    frame_stb = 1; frame_byte = b; tick(); frame_stb = 0;
  endtask
  task automatic idle_ev();
    idle_stb = 1; tick(); idle_stb = 0;
  endtask
  task automatic req();
    mute_req = 1; tick(); mute_req = 0;
  endtask
  task automatic clr_rx();
    rxne_clr = 1; tick(); rxne_clr = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) tick();
    rst = 0;
    tick();
    // R12 reset state
    chk("R12 reset mute", mute_o, 0);
    chk("R12 reset rxne", rxne_o, 0);
    chk("R12 reset irq", rx_irq_o, 0);
    chk("R12 reset data", rx_data_o, 0);

    // R1 mute disabled
    req();
    chk("R1 req ignored", mute_o, 0);
    send(8'h41);
    chk("R1 rxne", rxne_o, 1);
    chk("R1 data", rx_data_o, 8'h41);
    clr_rx();
    chk("R13 rxne clear", rxne_o, 0);

    // R6 receiver re-enabled, line busy until an idle strobe
    idle_ev();
    idle_clr = 1; tick(); idle_clr = 0;
    chk("R13 idle clear", idle_o, 0);
    rx_enable = 0; tick(); rx_enable = 1;
    mute_en = 1; tick();
    req();
    chk("R6 R3 request accepted after enable", mute_o, 1);

    // R2 muted: nothing reported
    rxne_ie = 1; idle_ie = 1;
    send(8'h55);
    chk("R2 rxne held", rxne_o, 0);
    chk("R2 irq low", rx_irq_o, 0);
    chk("R2 mute reads 1", mute_o, 1);

    // R4 idle wake
    idle_ev();
    chk("R4 woke", mute_o, 0);
    chk("R4 idle flag not set", idle_o, 0);

    // R5 request on idle line ignored
    req();
    chk("R5 stays unmuted", mute_o, 0);

    // R11 first frame after wake
    send(8'h12);
    chk("R11 rxne", rxne_o, 1);
    chk("R11 irq", rx_irq_o, 1);
    chk("R11 data", rx_data_o, 8'h12);
    clr_rx();
    chk("R13 irq drops", rx_irq_o, 0);

    // R13 idle flag and interrupt
    idle_ev();
    chk("R13 idle set", idle_o, 1);
    chk("R13 idle irq", rx_irq_o, 1);
    idle_clr = 1; tick(); idle_clr = 0;
    chk("R13 idle cleared", idle_o, 0);

    // R3 on a busy line, then R12 enable drop
    send(8'h07); clr_rx();
    req();
    chk("R3 mute set", mute_o, 1);
    mute_en = 0; tick();
    chk("R12 forced off", mute_o, 0);
    mute_en = 1;

    // Address wake, 7 bits
    wake_sel = 1; addr7_sel = 1; node_addr = 7'h25;
    req();
    chk("R10 addr mode request", mute_o, 1);
    send(8'h12);
    chk("R7 data keeps mute", mute_o, 1);
    chk("R7 data not reported", rxne_o, 0);
    send(8'hA6);
    chk("R10 miss stays muted", mute_o, 1);
    send(8'hA5);
    chk("R9 match wakes", mute_o, 0);
    chk("R10 match not reported", rxne_o, 0);
    send(8'h33);
    chk("R7 data reported", rxne_o, 1);
    chk("R7 data value", rx_data_o, 8'h33);
    clr_rx();
    send(8'hB5);
    chk("R9 upper bits compared", mute_o, 1);
    chk("R10 miss not reported", rxne_o, 0);

    // R8 4-bit compare
    addr7_sel = 0;
    send(8'h85);
    chk("R8 low nibble match", mute_o, 0);
    send(8'h86);
    chk("R8 nibble miss", mute_o, 1);
    send(8'hF5);
    chk("R8 bits 6:4 ignored", mute_o, 0);
    cmp_model("R8 model");

    // Mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      mute_en   = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 49) == 0) wake_sel = $urandom_range(0, 1);
      if ($urandom_range(0, 49) == 0) addr7_sel = $urandom_range(0, 1);
      rx_enable = ($urandom_range(0, 29) != 0);
      rxne_ie   = $urandom_range(0, 1);
      idle_ie   = $urandom_range(0, 1);
      frame_stb = (r < 30);
      idle_stb  = (r >= 30 && r < 40);
      mute_req  = (r >= 40 && r < 50);
      rxne_clr  = ($urandom_range(0, 5) == 0);
      idle_clr  = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 2))
        0: frame_byte = {1'b1, node_addr};
        1: frame_byte = {1'b1, 7'($urandom)};
        default: frame_byte = {1'b0, 7'($urandom)};
      endcase
      tick();
      cmp_model("R2 R10 R13 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule